// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined fixed-point arithmetic slice for filters. Two signed operands are first summed by a pre-adder. The sum is multiplied by a signed coefficient, and the product goes into a wide signed accumulator. The pre-adder lets a symmetric filter fold its mirrored samples into one multiply, which roughly halves the number of multiplies it needs.

Two control bits travel with the operands through the pipeline. One bit chooses between the pre-add sum and the first operand alone. The other bit chooses between reloading the accumulator and adding to it. In load mode the accumulator takes the product plus a cascade input. The cascade output always mirrors the accumulator, so slices can be chained into a systolic FIR filter. A single slice can also be time-shared across taps or channels.

Three pipeline stages are optional and are chosen by parameters: the operand capture, the pre-adder output and the product. The accumulator is always a register. Each stage has its own clock enable.

Top module: `macPreAddSlice`

## Requirements
- R1: With `preAddEn`=1, the multiplier operand is the exact 27-bit signed sum `aIn + dIn`. There is no wrap even when both inputs sit at their most negative or most positive value. This sum is multiplied by the signed `bIn`.
- R2: With `preAddEn`=0, the multiplier operand is `aIn` alone, and `dIn` has no effect on the result.
- R3: With `accLoad`=1, the accumulator becomes the product plus `casIn`, and its previous contents are discarded.
- R4: With `accLoad`=0, the accumulator becomes its previous value plus the product, and `casIn` has no effect.
- R5: The latency from operand capture to the updated `accOut` is IN_REG+PRE_REG+MUL_REG+1 cycles, which is 4 with the defaults. The two control bits are delayed to match their operands. `casIn` is sampled at the accumulator stage.
- R6: When a stage's clock enable is low, that stage holds its contents. With `ceAcc` low, `accOut` does not change. With `ceIn` low, newly presented operands never reach the accumulator.
- R7: `casOut` equals `accOut` in every cycle.
- R8: The asynchronous active-low reset `rstN` clears every pipeline stage and the accumulator to zero.
- R9: The accumulator is 48-bit two's complement. Sums of many products that exceed the 45-bit product range are kept exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceIn | input | 1 | Enable for the operand capture stage |
| cePre | input | 1 | Enable for the pre-adder output stage |
| ceMul | input | 1 | Enable for the product stage |
| ceAcc | input | 1 | Enable for the accumulator |
| preAddEn | input | 1 | 1: use aIn+dIn, 0: use aIn alone |
| accLoad | input | 1 | 1: load product+casIn, 0: add product to accumulator |
| aIn | input | 26 | Signed pre-adder operand A |
| dIn | input | 26 | Signed pre-adder operand D |
| bIn | input | 18 | Signed coefficient |
| casIn | input | 48 | Signed cascade input from the previous slice |
| accOut | output | 48 | Signed accumulator value |
| casOut | output | 48 | Cascade output to the next slice, equal to accOut |

## Verification
The bench builds two copies side by side on the same stimulus. One copy has all three optional stages enabled, which gives a four-cycle latency. The other copy has none, which gives a single-cycle latency. Comparing them shows that the control bits and the cascade sample stay aligned with their operands whichever stages are present. With the full copy, the bench can watch the result still absent one cycle early, and it can stall an individual stage while the others keep moving. With the lean copy, it can confirm that the same arithmetic appears after one edge.

// File: rtl/macPkg.sv
package macPkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic enIn;     // operand capture stage enable
    logic enPre;    // pre-adder output stage enable
    logic enMul;    // product stage enable
    logic enAcc;    // accumulator enable
    logic selSum;   // aligned with captured operands: use a+d
    logic loadAcc;  // aligned with product: reload accumulator
  } macStrobe_t;

endpackage

// File: rtl/macStage.sv
module macStage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)   q <= '0;
        else if (ce) q <= d;
      end
    end else begin : g_wire
      logic unusedStage;
      assign unusedStage = clk ^ rstN ^ ce;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/macCtrl.sv
module macCtrl
  import macPkg::*;
#(
  parameter bit IN_REG  = 1'b1,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceIn,
  input  logic       cePre,
  input  logic       ceMul,
  input  logic       ceAcc,
  input  logic       preAddEn,
  input  logic       accLoad,
  output macStrobe_t strobe
);

  logic [1:0] inCtl;   // {preAdd, load} at the operand stage
  logic       preLoad;
  logic       mulLoad;

  macStage #(.W(2), .EN(IN_REG)) u_inCtl (
    .clk(clk), .rstN(rstN), .ce(ceIn), .d({preAddEn, accLoad}), .q(inCtl)
  );
  macStage #(.W(1), .EN(PRE_REG)) u_preCtl (
    .clk(clk), .rstN(rstN), .ce(cePre), .d(inCtl[0]), .q(preLoad)
  );
  macStage #(.W(1), .EN(MUL_REG)) u_mulCtl (
    .clk(clk), .rstN(rstN), .ce(ceMul), .d(preLoad), .q(mulLoad)
  );

  always_comb begin
    strobe.enIn    = ceIn;
    strobe.enPre   = cePre;
    strobe.enMul   = ceMul;
    strobe.enAcc   = ceAcc;
    strobe.selSum  = inCtl[1];
    strobe.loadAcc = mulLoad;
  end

endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macPkg::*;
#(
  parameter int A_W     = 26,
  parameter int B_W     = 18,
  parameter int ACC_W   = 48,
  parameter bit IN_REG  = 1'b1,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  macStrobe_t              strobe,
  input  logic signed [A_W-1:0]   aIn,
  input  logic signed [A_W-1:0]   dIn,
  input  logic signed [B_W-1:0]   bIn,
  input  logic signed [ACC_W-1:0] casIn,
  output logic signed [ACC_W-1:0] accOut
);

  localparam int SUM_W  = A_W + 1;
  localparam int PROD_W = SUM_W + B_W;
  localparam int IN_W   = 2 * A_W + B_W;
  localparam int PRE_W  = SUM_W + B_W;

  // Operand capture
  logic [IN_W-1:0]        inBus;
  logic signed [A_W-1:0]  aQ, dQ;
  logic signed [B_W-1:0]  bQ;

  macStage #(.W(IN_W), .EN(IN_REG)) u_inStage (
    .clk(clk), .rstN(rstN), .ce(strobe.enIn), .d({aIn, dIn, bIn}), .q(inBus)
  );
  assign aQ = inBus[IN_W-1 -: A_W];
  assign dQ = inBus[B_W +: A_W];
  assign bQ = inBus[B_W-1:0];

  // Pre-adder, one bit wider than its operands
  logic signed [SUM_W-1:0] preSum;
  always_comb begin
    if (strobe.selSum) preSum = SUM_W'(aQ) + SUM_W'(dQ);
    else               preSum = SUM_W'(aQ);
  end

  logic [PRE_W-1:0]        preBus;
  logic signed [SUM_W-1:0] sumQ;
  logic signed [B_W-1:0]   coefQ;

  macStage #(.W(PRE_W), .EN(PRE_REG)) u_preStage (
    .clk(clk), .rstN(rstN), .ce(strobe.enPre), .d({preSum, bQ}), .q(preBus)
  );
  assign sumQ  = preBus[PRE_W-1 -: SUM_W];
  assign coefQ = preBus[B_W-1:0];

  // Signed multiplier
  logic signed [PROD_W-1:0] product;
  assign product = sumQ * coefQ;

  logic signed [PROD_W-1:0] prodQ;
  macStage #(.W(PROD_W), .EN(MUL_REG)) u_mulStage (
    .clk(clk), .rstN(rstN), .ce(strobe.enMul), .d(product), .q(prodQ)
  );

  // Accumulator, always registered
  logic signed [ACC_W-1:0] accQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             accQ <= '0;
    else if (strobe.enAcc) accQ <= (strobe.loadAcc ? casIn : accQ) + ACC_W'(prodQ);
  end

  assign accOut = accQ;

endmodule

// File: rtl/macPreAddSlice.sv
module macPreAddSlice
  import macPkg::*;
#(
  parameter int A_W     = 26,
  parameter int B_W     = 18,
  parameter int ACC_W   = 48,
  parameter bit IN_REG  = 1'b1,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceIn,
  input  logic                    cePre,
  input  logic                    ceMul,
  input  logic                    ceAcc,
  input  logic                    preAddEn,
  input  logic                    accLoad,
  input  logic signed [A_W-1:0]   aIn,
  input  logic signed [A_W-1:0]   dIn,
  input  logic signed [B_W-1:0]   bIn,
  input  logic signed [ACC_W-1:0] casIn,
  output logic signed [ACC_W-1:0] accOut,
  output logic signed [ACC_W-1:0] casOut
);

  macStrobe_t strobe;

  macCtrl #(.IN_REG(IN_REG), .PRE_REG(PRE_REG), .MUL_REG(MUL_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .cePre(cePre), .ceMul(ceMul),
    .ceAcc(ceAcc), .preAddEn(preAddEn), .accLoad(accLoad), .strobe(strobe)
  );

  macDatapath #(
    .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W),
    .IN_REG(IN_REG), .PRE_REG(PRE_REG), .MUL_REG(MUL_REG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aIn(aIn), .dIn(dIn),
    .bIn(bIn), .casIn(casIn), .accOut(accOut)
  );

  // R7: cascade output mirrors the accumulator
  assign casOut = accOut;

endmodule

// File: rtl/macPreAddSlice_chk.sv
module macPreAddSlice_chk #(
  parameter int A_W     = 26,
  parameter int B_W     = 18,
  parameter int ACC_W   = 48,
  parameter bit IN_REG  = 1'b1,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    ceIn,
  input logic                    cePre,
  input logic                    ceMul,
  input logic                    ceAcc,
  input logic                    preAddEn,
  input logic                    accLoad,
  input logic signed [A_W-1:0]   aIn,
  input logic signed [A_W-1:0]   dIn,
  input logic signed [B_W-1:0]   bIn,
  input logic signed [ACC_W-1:0] casIn,
  input logic signed [ACC_W-1:0] accOut,
  input logic signed [ACC_W-1:0] casOut
);

  localparam int LAT = int'(IN_REG) + int'(PRE_REG) + int'(MUL_REG) + 1;

  function automatic logic signed [ACC_W-1:0] refProd(
    input logic signed [A_W-1:0] a,
    input logic signed [A_W-1:0] d,
    input logic signed [B_W-1:0] b,
    input logic                  pre
  );
    logic signed [A_W:0] s;
    s = pre ? ((A_W+1)'(a) + (A_W+1)'(d)) : (A_W+1)'(a);
    return ACC_W'(s) * ACC_W'(b);
  endfunction

  // Consecutive edges with every stage enabled since reset
  logic [2:0] ceRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ceRun <= '0;
    else if (ceIn && cePre && ceMul && ceAcc) begin
      if (ceRun != 3'd7) ceRun <= ceRun + 3'd1;
    end else                                ceRun <= '0;
  end

  logic unusedChk;
  assign unusedChk = ^casOut;

  // R8: reset clears the accumulator
  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> accOut == '0);

  // R6: accumulator enable low freezes the result
  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ceAcc |=> $stable(accOut));

  // R3 and R5: a load lands after the pipeline latency with cascade added
  assert_load_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ceRun >= 3'(LAT) && $past(accLoad, LAT)) |->
      accOut == $past(casIn) +
                refProd($past(aIn, LAT), $past(dIn, LAT), $past(bIn, LAT), $past(preAddEn, LAT)));

  // R4: accumulate adds the delayed product to the previous total
  assert_accumulate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ceRun >= 3'(LAT) && !$past(accLoad, LAT)) |->
      accOut == $past(accOut) +
                refProd($past(aIn, LAT), $past(dIn, LAT), $past(bIn, LAT), $past(preAddEn, LAT)));

endmodule

bind macPreAddSlice macPreAddSlice_chk #(
  .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W),
  .IN_REG(IN_REG), .PRE_REG(PRE_REG), .MUL_REG(MUL_REG)
) u_chk (.*);

// File: tb/macPreAddSlice_tb.sv
module macPreAddSlice_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int A_W   = 26;
  localparam int B_W   = 18;
  localparam int ACC_W = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceIn = 1'b1, cePre = 1'b1, ceMul = 1'b1, ceAcc = 1'b1;
  logic preAddEn = 1'b1, accLoad = 1'b0;
  logic signed [A_W-1:0]   aIn = '0, dIn = '0;
  logic signed [B_W-1:0]   bIn = '0;
  logic signed [ACC_W-1:0] casIn = '0;
  logic signed [ACC_W-1:0] accOut, casOut, leanAcc, leanCas;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  macPreAddSlice u_dut (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .cePre(cePre), .ceMul(ceMul), .ceAcc(ceAcc),
    .preAddEn(preAddEn), .accLoad(accLoad), .aIn(aIn), .dIn(dIn), .bIn(bIn),
    .casIn(casIn), .accOut(accOut), .casOut(casOut)
  );

  macPreAddSlice #(.IN_REG(1'b0), .PRE_REG(1'b0), .MUL_REG(1'b0)) u_dutLean (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .cePre(cePre), .ceMul(ceMul), .ceAcc(ceAcc),
    .preAddEn(preAddEn), .accLoad(accLoad), .aIn(aIn), .dIn(dIn), .bIn(bIn),
    .casIn(casIn), .accOut(leanAcc), .casOut(leanCas)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint prod(input longint a, input longint d, input longint b, input bit pre);
    return (pre ? (a + d) : a) * b;
  endfunction

  // Present one operand set, return after the capturing edge (at a negedge)
  task automatic step(input longint a, input longint d, input longint b, input bit pre, input bit load);
    aIn = a[A_W-1:0];
    dIn = d[A_W-1:0];
    bIn = b[B_W-1:0];
    preAddEn = pre;
    accLoad = load;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) step(0, 0, 0, 1'b1, 1'b0);
  endtask

  task automatic testReset();
    check("R8 reset accOut", accOut, 0);
    check("R8 reset casOut", casOut, 0);
    check("R8 reset lean accOut", leanAcc, 0);
  endtask

  task automatic testLatencyLoad();
    longint exp = prod(1000, -300, -77, 1'b1) + 5;
    casIn = 48'sd5;
    step(1000, -300, -77, 1'b1, 1'b1);
    check("R5 lean result after one edge", leanAcc, exp);
    idle(2);
    check("R5 full result not yet visible", accOut, 0);
    idle(1);
    check("R3 load product plus cascade", accOut, exp);
    check("R7 casOut follows accOut", casOut, exp);
    check("R7 lean casOut", leanCas, exp);
  endtask

  task automatic testExtremes();
    longint exp1 = prod(-(64'sd1 <<< 25), -(64'sd1 <<< 25), -(64'sd1 <<< 17), 1'b1);
    longint pmax = (64'sd1 <<< 25) - 1;
    longint bmax = (64'sd1 <<< 17) - 1;
    longint exp2 = prod(pmax, pmax, bmax, 1'b1);
    casIn = '0;
    step(-(64'sd1 <<< 25), -(64'sd1 <<< 25), -(64'sd1 <<< 17), 1'b1, 1'b1);
    idle(3);
    check("R1 most negative pre-add sum", accOut, exp1);
    check("R1 most negative lean", leanAcc, exp1);
    step(pmax, pmax, bmax, 1'b1, 1'b1);
    idle(3);
    check("R1 most positive pre-add sum", accOut, exp2);
    check("R1 most positive lean", leanAcc, exp2);
  endtask

  task automatic testBypass();
    longint exp = 12345 * -321 - 9;
    casIn = -48'sd9;
    step(12345, 999999, -321, 1'b0, 1'b1);
    idle(3);
    check("R2 bypass ignores dIn", accOut, exp);
    check("R2 bypass lean", leanAcc, exp);
  endtask

  task automatic testAccumulate();
    longint exp = prod(10, 20, 3, 1'b1) + 777 + prod(-50, 5, 7, 1'b1)
                + prod(100, 4444, -2, 1'b0) + prod(8000, -1, 11, 1'b1);
    casIn = 48'sd777;
    step(10, 20, 3, 1'b1, 1'b1);
    step(-50, 5, 7, 1'b1, 1'b0);
    step(100, 4444, -2, 1'b0, 1'b0);
    step(8000, -1, 11, 1'b1, 1'b0);
    idle(3);
    check("R4 running sum ignores casIn", accOut, exp);
    check("R4 running sum lean", leanAcc, exp);
  endtask

  task automatic testWide();
    longint big = -(64'sd1 <<< 25);
    longint bneg = -(64'sd1 <<< 17);
    longint exp = 12 * (64'sd1 <<< 43);
    casIn = '0;
    step(big, big, bneg, 1'b1, 1'b1);
    repeat (11) step(big, big, bneg, 1'b1, 1'b0);
    idle(3);
    check("R9 sum beyond product width", accOut, exp);
    check("R9 sum beyond product width lean", leanAcc, exp);
  endtask

  task automatic testAccEnable();
    longint held = longint'(accOut);
    ceAcc = 1'b0;
    step(5, 5, 5, 1'b1, 1'b1);
    idle(5);
    check("R6 ceAcc low holds accOut", accOut, held);
    check("R6 ceAcc low holds lean", leanAcc, held);
    ceAcc = 1'b1;
    idle(2);
    check("R6 op lost while ceAcc low", accOut, held);
  endtask

  task automatic testInEnable();
    longint held = longint'(accOut);
    ceIn = 1'b0;
    step(5, 5, 5, 1'b1, 1'b1);
    idle(4);
    ceIn = 1'b1;
    idle(4);
    check("R6 ceIn low blocks operands", accOut, held);
  endtask

  task automatic testMidReset();
    casIn = '0;
    step(3, 4, 5, 1'b1, 1'b1);
    idle(3);
    check("R3 load before reset", accOut, 35);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 reset mid run", accOut, 0);
    check("R8 reset mid run lean", leanAcc, 0);
    check("R7 casOut after reset", casOut, 0);
    rstN = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLatencyLoad();
    testExtremes();
    testBypass();
    testAccumulate();
    testWide();
    testAccEnable();
    testInEnable();
    testMidReset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule